// File: doc/BRIEF.md
# Two-Nibble Seven-Segment Display Sequencer

This block presents an 8-bit value on one seven-segment digit by showing its two hexadecimal halves one after the other. It shows the upper four bits first, with the decimal point lit to mark that half. A short blank interval follows, then the lower four bits, then a longer blank interval. After that the cycle starts again. The asymmetric pattern of blank intervals lets a viewer tell where each byte begins. The value is captured once per cycle, so the two halves shown always come from the same byte.

A mode input selects a raw view. In that mode each of the eight input bits drives one segment or the decimal point directly and without delay. The timing engine keeps running in raw mode, so the sequence resumes at the point it had reached when nibble mode returns. The display time and both blank intervals are parameters counted in clock cycles.

Top module: `hex_digit_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer returns to the start of the upper-half display phase with its phase timer cleared, and it captures `value_in`. In the first cycle after reset, nibble mode shows the upper half of that captured value with the decimal point lit.
- R2: In nibble mode the phases repeat in this fixed order: upper half for `SHOW_CYC` cycles, blank for `GAP_SHORT` cycles, lower half for `SHOW_CYC` cycles, blank for `GAP_LONG` cycles. `GAP_LONG` must be at least twice `GAP_SHORT`.
- R3: During a display phase, `seg_n` carries the active-low glyph of the shown nibble. Bit 0 is segment a and bit 6 is segment g. The active-high patterns for 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71 (hex).
- R4: In nibble mode `dp_n` is 0 only during the upper-half phase and is 1 in every other phase.
- R5: During both blank phases in nibble mode, `seg_n` is 7'h7F and `dp_n` is 1.
- R6: `value_in` is captured only at reset and at the rising edge that ends the long blank phase. A change to `value_in` at any other time does not alter the digits shown until the next cycle begins.
- R7: When `raw_mode` is 1, `seg_n[i]` equals the inverse of `value_in[i]` for i = 0 to 6, and `dp_n` equals the inverse of `value_in[7]`, in the same cycle. The phase timer keeps advancing while `raw_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| value_in | input | 8 | Byte to display |
| raw_mode | input | 1 | 1 = bit-per-segment view, 0 = nibble sequence |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |
| dp_n | output | 1 | Active-low decimal point |

## Verification
The phase and the captured byte are registered, and the outputs are combinational from them. A phase change therefore appears in the cycle after the edge that causes it. In raw mode the outputs follow `value_in` with no cycle of delay. The bench keeps a cycle counter and a byte capture of its own, both updated on the rising edge by the rules in R1, R2 and R6. It compares the outputs one time unit after each falling edge, after the inputs driven at that falling edge have settled, so each registered result is checked in the cycle it is due and each raw result in the same cycle. Inputs change every seven cycles, which is out of step with the 16-cycle sequence, so input changes land in the middle of phases.

// File: rtl/hexseq_pkg.sv
package hexseq_pkg;

    typedef enum logic [1:0] {
        PH_UPPER = 2'd0,
        PH_GAP_S = 2'd1,
        PH_LOWER = 2'd2,
        PH_GAP_L = 2'd3
    } phase_t;

    typedef logic [6:0] seg_t;

    localparam seg_t SEG_BLANK_N = 7'h7F;

    // Active-high glyph, bit 0 = segment a ... bit 6 = segment g
    function automatic seg_t hex_glyph(input logic [3:0] nib);
        seg_t g;
        case (nib)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/hexseq_timer.sv
module hexseq_timer
    import hexseq_pkg::*;
#(
    parameter int unsigned SHOW_CYC  = 4,
    parameter int unsigned GAP_SHORT = 2,
    parameter int unsigned GAP_LONG  = 6
) (
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   wrap
);
    localparam int unsigned MAX_A  = (SHOW_CYC > GAP_SHORT) ? SHOW_CYC : GAP_SHORT;
    localparam int unsigned MAX_C  = (MAX_A > GAP_LONG) ? MAX_A : GAP_LONG;
    localparam int unsigned CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    phase_t           phase_q;
    phase_t           phase_nxt;
    logic             last;

    always_comb begin
        case (phase_q)
            PH_UPPER: begin limit = CNT_W'(SHOW_CYC - 1);  phase_nxt = PH_GAP_S; end
            PH_GAP_S: begin limit = CNT_W'(GAP_SHORT - 1); phase_nxt = PH_LOWER; end
            PH_LOWER: begin limit = CNT_W'(SHOW_CYC - 1);  phase_nxt = PH_GAP_L; end
            default:  begin limit = CNT_W'(GAP_LONG - 1);  phase_nxt = PH_UPPER; end
        endcase
    end

    assign last = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_UPPER;
            cnt_q   <= '0;
        end else if (last) begin
            phase_q <= phase_nxt;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase = phase_q;
    assign wrap  = (phase_q == PH_GAP_L) && last;

endmodule

// File: rtl/hexseq_capture.sv
module hexseq_capture #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wrap,
    input  logic [DW-1:0] value_in,
    output logic [DW-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            held <= value_in;
        end
    end
endmodule

// File: rtl/hexseq_seg_mux.sv
module hexseq_seg_mux
    import hexseq_pkg::*;
#(
    parameter int unsigned NSEG = 7
) (
    input  phase_t          phase,
    input  logic            raw_mode,
    input  logic [NSEG:0]   live,
    input  logic [NSEG:0]   held,
    output logic [NSEG-1:0] seg_n,
    output logic            dp_n
);
    localparam int unsigned HALF = (NSEG + 1) / 2;

    logic [HALF-1:0] nib;
    seg_t            glyph;
    logic [NSEG-1:0] raw_seg_n;

    assign nib   = (phase == PH_UPPER) ? held[NSEG:HALF] : held[HALF-1:0];
    assign glyph = hex_glyph(nib);

    for (genvar i = 0; i < NSEG; i++) begin : g_raw
        assign raw_seg_n[i] = ~live[i];
    end

    always_comb begin
        if (raw_mode) begin
            seg_n = raw_seg_n;
            dp_n  = ~live[NSEG];
        end else begin
            case (phase)
                PH_UPPER: begin seg_n = ~glyph; dp_n = 1'b0; end
                PH_LOWER: begin seg_n = ~glyph; dp_n = 1'b1; end
                default:  begin seg_n = SEG_BLANK_N; dp_n = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/hex_digit_sequencer.sv
module hex_digit_sequencer
    import hexseq_pkg::*;
#(
    parameter int unsigned SHOW_CYC  = 4,
    parameter int unsigned GAP_SHORT = 2,
    parameter int unsigned GAP_LONG  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] value_in,
    input  logic       raw_mode,
    output logic [6:0] seg_n,
    output logic       dp_n
);
    phase_t     phase;
    logic       wrap;
    logic [7:0] held;

    hexseq_timer #(
        .SHOW_CYC (SHOW_CYC),
        .GAP_SHORT(GAP_SHORT),
        .GAP_LONG (GAP_LONG)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .phase(phase),
        .wrap (wrap)
    );

    hexseq_capture #(.DW(8)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .value_in(value_in),
        .held    (held)
    );

    hexseq_seg_mux #(.NSEG(7)) u_mux (
        .phase   (phase),
        .raw_mode(raw_mode),
        .live    (value_in),
        .held    (held),
        .seg_n   (seg_n),
        .dp_n    (dp_n)
    );
endmodule

// File: rtl/hexseq_checker.sv
module hexseq_checker
    import hexseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [7:0] value_in,
    input logic       raw_mode,
    input logic [6:0] seg_n,
    input logic       dp_n,
    input phase_t     phase,
    input logic       wrap,
    input logic [7:0] held
);
    // R1: after reset, nibble mode opens on the upper half with dp lit
    a_r1_reset_upper: assert property (@(posedge clk)
        rst |=> (phase == PH_UPPER));

    // R2: phase order
    a_r2_upper_next: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_UPPER) |=> (phase == PH_UPPER || phase == PH_GAP_S));
    a_r2_gaps_next: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GAP_S) |=> (phase == PH_GAP_S || phase == PH_LOWER));
    a_r2_lower_next: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOWER) |=> (phase == PH_LOWER || phase == PH_GAP_L));
    a_r2_gapl_next: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GAP_L) |=> (phase == PH_GAP_L || phase == PH_UPPER));

    // R4: decimal point marks the upper half only
    a_r4_dp_marks_upper: assert property (@(posedge clk) disable iff (rst)
        !raw_mode |-> (dp_n == (phase != PH_UPPER)));

    // R5: blank during both gaps
    a_r5_gap_blank: assert property (@(posedge clk) disable iff (rst)
        (!raw_mode && (phase == PH_GAP_S || phase == PH_GAP_L))
            |-> (seg_n == 7'h7F && dp_n));

    // R6: captured byte holds between sequence starts
    a_r6_hold_capture: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(held));

    // R7: raw mode mirrors input inverted
    a_r7_raw_map: assert property (@(posedge clk) disable iff (rst)
        raw_mode |-> (({dp_n, seg_n} ^ value_in) == 8'hFF));
endmodule

bind hex_digit_sequencer hexseq_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .value_in(value_in),
    .raw_mode(raw_mode),
    .seg_n   (seg_n),
    .dp_n    (dp_n),
    .phase   (phase),
    .wrap    (wrap),
    .held    (held)
);

// File: tb/tb_hex_digit_sequencer.sv
module tb_hex_digit_sequencer;
    localparam int SHOW = 4;
    localparam int GS   = 2;
    localparam int GL   = 6;
    localparam int PER  = 2 * SHOW + GS + GL;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] value_in;
    logic       raw_mode;
    logic [6:0] seg_n;
    logic       dp_n;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    int  t_model  = 0;
    logic [7:0] snap_model = 8'h00;

    always #5 clk = ~clk;

    hex_digit_sequencer #(.SHOW_CYC(SHOW), .GAP_SHORT(GS), .GAP_LONG(GL)) dut (
        .clk(clk), .rst(rst), .value_in(value_in), .raw_mode(raw_mode),
        .seg_n(seg_n), .dp_n(dp_n)
    );

    // R3 glyph patterns, active high, bit0 = a
    function automatic logic [6:0] glyph(input logic [3:0] n);
        logic [6:0] tbl [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                                 7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return tbl[n];
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got {dp_n,seg_n}=%02h expected %02h (t=%0d)", tag, act, exp, t_model);
        end
    endtask

    // Reference sequence model, R1 R2 R6
    always @(posedge clk) begin
        if (rst) begin
            t_model    = 0;
            snap_model = value_in;
        end else if (t_model == PER - 1) begin
            t_model    = 0;
            snap_model = value_in;
        end else begin
            t_model = t_model + 1;
        end
    end

    // Per-cycle comparison away from the edge
    always @(negedge clk) begin
        #1;
        if (!done && rst !== 1'bx) begin
            if (raw_mode) begin
                check("R7", {dp_n, seg_n}, ~value_in);
            end else if (t_model < SHOW) begin
                check("R3/R4/R6 upper", {dp_n, seg_n}, {1'b0, ~glyph(snap_model[7:4])});
            end else if (t_model < SHOW + GS) begin
                check("R5/R2 short gap", {dp_n, seg_n}, 8'hFF);
            end else if (t_model < 2 * SHOW + GS) begin
                check("R3/R4/R6 lower", {dp_n, seg_n}, {1'b1, ~glyph(snap_model[3:0])});
            end else begin
                check("R5/R2 long gap", {dp_n, seg_n}, 8'hFF);
            end
        end
    end

    initial begin
        rst      = 1'b1;
        value_in = 8'hA7;
        raw_mode = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state shows upper half of captured byte
        #1 check("R1 reset state", {dp_n, seg_n}, {1'b0, ~glyph(4'hA)});
        @(negedge clk);
        rst = 1'b0;
        // Sweep all bytes in nibble mode, changes out of step with sequence (R2 R3 R6)
        for (int v = 0; v < 256; v++) begin
            value_in = v[7:0];
            repeat (7) @(negedge clk);
        end
        // Raw mode sweep (R7)
        raw_mode = 1'b1;
        for (int v = 0; v < 256; v++) begin
            value_in = v[7:0];
            @(negedge clk);
        end
        raw_mode = 1'b0;
        value_in = 8'h5E;
        repeat (2 * PER) @(negedge clk);
        // Raw excursion mid-sequence; timer keeps running (R7)
        raw_mode = 1'b1;
        repeat (3) @(negedge clk);
        raw_mode = 1'b0;
        repeat (PER + 5) @(negedge clk);
        // Mid-run reset (R1)
        rst      = 1'b1;
        value_in = 8'h3C;
        @(negedge clk);
        rst = 1'b0;
        value_in = 8'hF0;
        #1 check("R1 after mid reset", {dp_n, seg_n}, {1'b0, ~glyph(4'h3)});
        repeat (2 * PER + 3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule